// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a station-management master for Ethernet PHYs. Software describes a complete Clause 22 management transaction in a single 32-bit command word: the opcode, the PHY address, the register address and the write data. Setting the start/busy bit in the same write launches the transaction. The block then generates the management clock and serialises the frame. It releases the data line for the PHY's reply on reads, and loads the returned data into the low half of the same word.

Software polls the busy bit until it clears and then reads the result from that word. The result is either the register contents or a read-fail flag, which is set when the PHY never pulled the line low during turnaround. The word can be written again only once busy has cleared, so a transaction in flight cannot be corrupted. The management clock runs only while a transaction is in flight and rests low otherwise.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the command word reads as all zeros, `mdc` is low and `mdio_oe` is low.
- R2: A write accepted while idle with bit 29 set makes bit 29 read 1 from the next cycle until the frame ends, then 0. Bits 27:16 read back the opcode (27:26), PHY address (25:21) and register address (20:16) that were written.
- R3: Each frame is sampled on rising `mdc` in this order: 32 ones, start bits 0 then 1, the two opcode bits, the five PHY address bits, the five register address bits, two turnaround bits and 16 data bits. Every field goes out most significant bit first. For any opcode other than 10 (read), all 64 bits are driven, the turnaround is 1 then 0, and the data bits are command bits 15:0.
- R4: For opcode 10 the master stops driving (`mdio_oe` low) from the first turnaround bit to the end of the frame. It captures the 16 data bits, most significant bit first, into bits 15:0.
- R5: After a read, bit 28 reads 1 if the second turnaround bit was sampled high and 0 if it was sampled low. It reads 0 after any write or transaction of another opcode.
- R6: A write to the command word while bit 29 is set changes nothing and starts no second frame.
- R7: `mdc` has a period of 2*MDC_HALF clock cycles during a frame and stays low while idle. `mdio_o` changes only on a falling `mdc` edge while driven.
- R8: Bit 29 stays set for exactly 2*(PRE_BITS+32)*MDC_HALF+1 clock cycles per transaction.
- R9: Opcodes 00, 01 and 11 leave bits 15:0 holding the written data after the frame.
- R10: A write accepted while idle with bit 29 clear stores the fields, clears bit 28 and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr_en | input | 1 | Write strobe for the command word |
| cmd_wr_data | input | 32 | Command word to write |
| cmd_rd_data | output | 32 | Current command/status word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for `mdio_o` (low = released) |
| mdio_i | input | 1 | Sampled level of the management data line |

## Verification
Writes are swept with a walking one in the PHY address against a walking zero in the register address and varied data. This catches swapped fields, bit-order mistakes and off-by-one framing in the serialiser. Reads are swept over several reply patterns and address pairs, which separates correct capture order from reversed or shifted capture. A read with a silent PHY tells a working ack check apart from one that never sets the flag. Reserved opcodes, a write injected mid-frame and a write without the start bit show that the read path, the busy lock and the launch condition are each isolated.

// File: rtl/mdio_cmd_pkg.sv
// Shared field positions and types for the MDIO command controller.
// Assumes a 32-bit command word, of which bits 31:30 always read as zero.
package mdio_cmd_pkg;

    localparam int BUSY_BIT = 29;
    localparam int FAIL_BIT = 28;

    typedef enum logic [1:0] {
        OP_RSVD_LO = 2'b00,
        OP_WRITE   = 2'b01,
        OP_READ    = 2'b10,
        OP_RSVD_HI = 2'b11
    } mdio_op_e;

    // Packed image of bits 29:0 of the command word.
    typedef struct packed {
        logic        busy;
        logic        fail;
        mdio_op_e    op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
    } cmd_word_t;

endpackage

// File: rtl/mdio_mdc_gen.sv
// Management clock generator. While en is high, mdc toggles every HALF
// system clocks, starting low. The strobes mark the system-clock edge at
// which mdc rises or falls. While en is low, mdc is held low and the
// phase counter is cleared, so every frame starts at the same phase.
module mdio_mdc_gen #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);

    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(HALF - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    // Phase counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (cnt == CNT_TOP) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Edge strobes coincide with the edge that toggles mdc.
    always_comb begin
        wrap     = en && (cnt == CNT_TOP);
        rise_stb = wrap && !mdc;
        fall_stb = wrap && mdc;
    end

endmodule

// File: rtl/mdio_frame_engine.sv
// Frame serialiser for one Clause 22 transaction. On start it loads the
// whole frame into a shift register and drives its top bit. It shifts on
// every falling mdc strobe and samples the line on rising strobes. A read
// releases the line from the turnaround onward, samples the second
// turnaround bit as the ack and shifts in the 16 data bits.
// Assumes start is only asserted while the engine is inactive.
module mdio_frame_engine
    import mdio_cmd_pkg::*;
#(
    parameter int PRE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mdio_op_e    op,
    input  logic [4:0]  phy,
    input  logic [4:0]  regad,
    input  logic [15:0] wdata,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_i,
    output logic        active,
    output logic        done,
    output logic [15:0] rdata,
    output logic        nack,
    output logic        mdio_o,
    output logic        mdio_oe
);

    localparam int FW      = PRE_BITS + 32;
    localparam int IW      = $clog2(FW);
    localparam int TA_IDX  = PRE_BITS + 14;
    localparam logic [IW-1:0] TA_POS   = IW'(TA_IDX);
    localparam logic [IW-1:0] ACK_POS  = IW'(TA_IDX + 1);
    localparam logic [IW-1:0] DATA_POS = IW'(TA_IDX + 2);
    localparam logic [IW-1:0] LAST_POS = IW'(FW - 1);

    logic [FW-1:0] frame;
    logic [IW-1:0] idx;
    logic          is_rd;

    // Frame load, bit advance and end-of-frame detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            done   <= 1'b0;
            frame  <= '0;
            idx    <= '0;
            is_rd  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                idx    <= '0;
                is_rd  <= (op == OP_READ);
                frame  <= {{PRE_BITS{1'b1}}, 2'b01, op, phy, regad,
                           (op == OP_READ) ? 2'b11 : 2'b10, wdata};
            end else if (active && fall_stb) begin
                if (idx == LAST_POS) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    idx   <= idx + 1'b1;
                    frame <= {frame[FW-2:0], 1'b0};
                end
            end
        end
    end

    // Ack and read-data capture on rising mdc.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            nack  <= 1'b0;
        end else if (start) begin
            rdata <= '0;
            nack  <= 1'b0;
        end else if (active && rise_stb && is_rd) begin
            if (idx == ACK_POS) begin
                nack <= mdio_i;
            end
            if (idx >= DATA_POS) begin
                rdata <= {rdata[14:0], mdio_i};
            end
        end
    end

    // Line drive: the full frame for writes, everything before the turnaround for reads.
    always_comb begin
        mdio_o  = active && frame[FW-1];
        mdio_oe = active && (!is_rd || (idx < TA_POS));
    end

endmodule

// File: rtl/mdio_cmd_ctrl.sv
// MDIO management command controller top. Holds the packed command/status
// word, accepts software writes only while idle, launches the frame engine
// when the start bit is written, and loads the result on completion.
// Assumes the PHY side resolves the shared line into mdio_i externally.
module mdio_cmd_ctrl
    import mdio_cmd_pkg::*;
#(
    parameter int MDC_HALF = 4,
    parameter int PRE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr_en,
    input  logic [31:0] cmd_wr_data,
    output logic [31:0] cmd_rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    cmd_word_t   cmd_q;
    logic        accept;
    logic        start;
    logic        eng_active;
    logic        eng_done;
    logic        eng_nack;
    logic [15:0] eng_rdata;
    logic        rise_stb;
    logic        fall_stb;
    logic        unused_wr_bits;

    // Write acceptance and launch decode.
    always_comb begin
        accept         = cmd_wr_en && !cmd_q.busy;
        start          = accept && cmd_wr_data[BUSY_BIT];
        unused_wr_bits = ^{cmd_wr_data[31:30], cmd_wr_data[FAIL_BIT]};
    end

    // Command/status word: software load, then completion update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (accept) begin
            cmd_q.busy  <= cmd_wr_data[BUSY_BIT];
            cmd_q.fail  <= 1'b0;
            cmd_q.op    <= mdio_op_e'(cmd_wr_data[27:26]);
            cmd_q.phy   <= cmd_wr_data[25:21];
            cmd_q.regad <= cmd_wr_data[20:16];
            cmd_q.data  <= cmd_wr_data[15:0];
        end else if (eng_done) begin
            cmd_q.busy <= 1'b0;
            if (cmd_q.op == OP_READ) begin
                cmd_q.data <= eng_rdata;
                cmd_q.fail <= eng_nack;
            end
        end
    end

    assign cmd_rd_data = {2'b00, cmd_q};

    mdio_mdc_gen #(
        .HALF(MDC_HALF)
    ) u_mdc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (eng_active),
        .mdc     (mdc),
        .rise_stb(rise_stb),
        .fall_stb(fall_stb)
    );

    mdio_frame_engine #(
        .PRE_BITS(PRE_BITS)
    ) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op      (mdio_op_e'(cmd_wr_data[27:26])),
        .phy     (cmd_wr_data[25:21]),
        .regad   (cmd_wr_data[20:16]),
        .wdata   (cmd_wr_data[15:0]),
        .rise_stb(rise_stb),
        .fall_stb(fall_stb),
        .mdio_i  (mdio_i),
        .active  (eng_active),
        .done    (eng_done),
        .rdata   (eng_rdata),
        .nack    (eng_nack),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
// Protocol checker for mdio_cmd_ctrl, attached by bind. Observes only the
// command interface and the management pins.
module mdio_cmd_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr_en,
    input logic        start_req,
    input logic        busy,
    input logic [11:0] fields,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);

    // R2
    launch_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && cmd_wr_en && start_req |=> busy);

    // R2
    mdc_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> busy);

    // R6
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cmd_wr_en |=> $stable(fields));

    // R7
    idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc && !mdio_oe);

    // R7
    drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe && $past(mdio_oe) && !$stable(mdio_o) |-> $fell(mdc));

endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr_en(cmd_wr_en),
    .start_req(cmd_wr_data[29]),
    .busy     (cmd_rd_data[29]),
    .fields   (cmd_rd_data[27:16]),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
);

// File: tb/sim_mdio_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_mdio_cmd_ctrl;

    localparam int HALF     = 4;
    localparam int PRE      = 32;
    localparam int FW       = PRE + 32;
    localparam int BUSY_CYC = 2 * FW * HALF + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr_en = 1'b0;
    logic [31:0] cmd_wr_data = '0;
    wire  [31:0] cmd_rd_data;
    wire         mdc;
    wire         mdio_o;
    wire         mdio_oe;
    logic        mdio_i;

    logic        phy_en = 1'b0;
    logic        phy_val = 1'b1;
    logic [15:0] rsp_data = '0;
    bit          rsp_nack = 1'b0;
    int          rise_cnt = 0;
    int          clash = 0;
    logic [FW-1:0] got = '0;
    logic [FW-1:0] oe_seen = '0;
    realtime     t_r0 = 0.0;
    realtime     t_r1 = 0.0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    // Line resolution: master, PHY or pull-up.
    always_comb mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

    mdio_cmd_ctrl #(.MDC_HALF(HALF), .PRE_BITS(PRE)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
        .cmd_rd_data(cmd_rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i));

    // PHY model: record each sampled bit.
    always @(posedge mdc) begin
        if (rise_cnt < FW) begin
            got[FW-1-rise_cnt]     = mdio_i;
            oe_seen[FW-1-rise_cnt] = mdio_oe;
            if (rise_cnt == 0) t_r0 = $realtime;
            if (rise_cnt == 1) t_r1 = $realtime;
        end
        if (mdio_oe && phy_en) clash++;
        rise_cnt++;
    end

    // PHY model: answer a read after the turnaround.
    always @(negedge mdc) begin
        if (rise_cnt >= PRE + 14 && rise_cnt < FW &&
            got[FW-1-(PRE+2)] == 1'b1 && got[FW-1-(PRE+3)] == 1'b0) begin
            if (rise_cnt == PRE + 14) begin
                phy_en = 1'b0;
            end else if (rise_cnt == PRE + 15) begin
                phy_en  = !rsp_nack;
                phy_val = 1'b0;
            end else begin
                phy_val = rsp_data[FW-1-rise_cnt];
            end
        end else begin
            phy_en = 1'b0;
        end
    end

    task automatic report();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Launch one transaction and check frame, timing and readback.
    task automatic run_cmd(input logic [1:0] op, input logic [4:0] phy,
                           input logic [4:0] ra, input logic [15:0] wd,
                           input bit nack, input logic [15:0] rd, input int intrude_at);
        int cyc;
        bit is_rd;
        logic [FW-1:0] exp_frame;
        logic [FW-1:0] exp_oe;
        logic [15:0]   exp_data;
        is_rd    = (op == 2'b10);
        rsp_data = rd;
        rsp_nack = nack;
        rise_cnt = 0;
        clash    = 0;
        @(negedge clk);
        cmd_wr_en   = 1'b1;
        cmd_wr_data = {2'b00, 1'b1, 1'b0, op, phy, ra, wd};
        @(negedge clk);
        cmd_wr_en = 1'b0;
        cyc = 0;
        while (cmd_rd_data[29] === 1'b1 && cyc < 5000) begin
            cyc++;
            if (cyc == intrude_at) begin
                cmd_wr_en   = 1'b1;
                cmd_wr_data = ~{2'b00, 1'b0, 1'b0, op, phy, ra, wd};
            end else begin
                cmd_wr_en = 1'b0;
            end
            @(negedge clk);
        end
        cmd_wr_en = 1'b0;
        if (is_rd) begin
            exp_data  = nack ? 16'hFFFF : rd;
            exp_frame = {{PRE{1'b1}}, 2'b01, op, phy, ra, 1'b1, nack, exp_data};
            exp_oe    = {{(PRE+14){1'b1}}, 18'b0};
            chk("R4", "read frame on line", 64'(exp_frame), 64'(got));
            chk("R4", "release mask", 64'(exp_oe), 64'(oe_seen));
            chk("R4", "read data readback", 64'(cmd_rd_data[15:0]), 64'(exp_data));
            chk("R5", "read-fail flag", 64'(cmd_rd_data[28]), 64'(nack));
        end else begin
            exp_frame = {{PRE{1'b1}}, 2'b01, op, phy, ra, 2'b10, wd};
            chk("R3", "write frame on line", 64'(got), 64'(exp_frame));
            chk("R3", "fully driven", 64'(oe_seen), {64{1'b1}});
            chk("R9", "data kept", 64'(cmd_rd_data[15:0]), 64'(wd));
            chk("R5", "fail clear", 64'(cmd_rd_data[28]), 64'd0);
        end
        chk("R3", "rising edges per frame", 64'(rise_cnt), 64'(FW));
        chk("R8", "busy cycles", 64'(cyc), 64'(BUSY_CYC));
        chk("R7", "mdc period ns", 64'(int'(t_r1 - t_r0)), 64'(2 * HALF * 4));
        chk("R2", "fields readback", 64'(cmd_rd_data[27:16]), 64'({op, phy, ra}));
        chk("R2", "busy cleared", 64'(cmd_rd_data[29]), 64'd0);
        chk("R4", "no line contention", 64'(clash), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R8 watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "word after reset", 64'(cmd_rd_data), 64'd0);
        chk("R1", "mdc after reset", 64'(mdc), 64'd0);
        chk("R1", "oe after reset", 64'(mdio_oe), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "word idle", 64'(cmd_rd_data), 64'd0);

        // R3: write sweep, walking one against walking zero
        for (int i = 0; i < 5; i++)
            run_cmd(2'b01, 5'(1 << i), ~5'(1 << i), 16'hA5C3 ^ 16'(16'h1111 * i), 1'b0, 16'h0, 0);

        // R4: read sweep
        for (int i = 0; i < 4; i++)
            run_cmd(2'b10, 5'(i * 7 + 1), 5'(31 - i * 5), 16'h0,
                    1'b0, 16'h8001 ^ (16'h0F0F << i), 0);

        // R5: silent PHY, then a good read clears the flag
        run_cmd(2'b10, 5'd9, 5'd2, 16'h0, 1'b1, 16'h1234, 0);
        run_cmd(2'b10, 5'd9, 5'd3, 16'h0, 1'b0, 16'h0F0F, 0);

        // R9: reserved opcodes drive the whole frame
        run_cmd(2'b11, 5'd21, 5'd10, 16'h5AA5, 1'b0, 16'h0, 0);
        run_cmd(2'b00, 5'd10, 5'd21, 16'hC001, 1'b0, 16'h0, 0);

        // R6: write during busy is ignored and starts nothing
        run_cmd(2'b01, 5'd17, 5'd6, 16'h2468, 1'b0, 16'h0, 100);
        repeat (40) @(negedge clk);
        chk("R6", "no relaunch busy", 64'(cmd_rd_data[29]), 64'd0);
        chk("R6", "no relaunch edges", 64'(rise_cnt), 64'(FW));
        chk("R6", "data intact", 64'(cmd_rd_data[15:0]), 64'h2468);

        // R10: store without launch, clears fail flag
        run_cmd(2'b10, 5'd4, 5'd4, 16'h0, 1'b1, 16'h0, 0);
        chk("R10", "fail set before store", 64'(cmd_rd_data[28]), 64'd1);
        rise_cnt = 0;
        @(negedge clk);
        cmd_wr_en   = 1'b1;
        cmd_wr_data = {2'b00, 1'b0, 1'b1, 2'b01, 5'd3, 5'd4, 16'hABCD};
        @(negedge clk);
        cmd_wr_en = 1'b0;
        repeat (40) @(negedge clk);
        chk("R10", "stored word", 64'(cmd_rd_data),
            64'({2'b00, 1'b0, 1'b0, 2'b01, 5'd3, 5'd4, 16'hABCD}));
        chk("R10", "no frame edges", 64'(rise_cnt), 64'd0);
        chk("R7", "mdc idle low", 64'(mdc), 64'd0);

        report();
    end

endmodule